// File: doc/BRIEF.md
# Selectable-Polynomial Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per clock. A 3-bit select input picks one of eight fixed polynomial settings from an internal constant table. Each setting fixes a degree (16, 12 or 8), a generator polynomial, a shift direction and a start value. Serial data is divided modulo 2 by the selected polynomial in a shared 16-bit remainder register. When the block generates, the remainder left after the last message bit is the check word, and it is available in parallel for the sender to append. When the block checks, the message and its appended check word are shifted through the same polynomial, and a zero remainder means no error was detected.

A message starts with a one-cycle synchronous clear, which loads the start value of the selected setting. The bits follow with the enable high. The select input must stay constant for the whole message. Normal settings take each byte most significant bit first and need the check word appended from its top bit down. Reversed settings take each byte least significant bit first and need the check word appended from bit 0 up. An active-low master reset clears the register at any time, with no clock.

Top module: `sel_crc_engine`

## Requirements
- R1: The select values 0 to 7 choose these settings, given as degree, polynomial without its top term, direction and start value: 0 = 16, 0x8005, normal, 0; 1 = 16, 0xA001, reversed, 0; 2 = 12, 0x80F, normal, 0; 3 = 8, 0x07, normal, 0; 4 = 16, 0x1021, normal, 0; 5 = 16, 0x8408, reversed, 0; 6 = 8, 0x01, normal, 0; 7 = 16, 0x8005, normal, 0xFFFF.
- R2: For a normal setting of degree N, each enabled clock computes fb = data_i XOR r[N-1]. The register then becomes ((r << 1) masked to N bits) XOR (fb ? poly : 0). Over the ASCII string "123456789" fed MSB first, check_o is 0xFEE8 for select 0, 0x0F5B for select 2, 0x00F4 for select 3, 0x31C3 for select 4, 0x0031 for select 6 and 0xAEE7 for select 7.
- R3: For a reversed setting, each enabled clock computes fb = data_i XOR r[0]. The register then becomes (r >> 1) XOR (fb ? poly : 0). Over "123456789" fed LSB first, check_o is 0xBB3D for select 1 and 0x2189 for select 5.
- R4: For a setting of degree N below 16, check_o bits 15 down to N read zero. Only the low N register bits take part in the shift and in the error decision.
- R5: err_o is high exactly when the low N bits of the remainder are nonzero. After a message followed by its own check word, in the bit order of R2 or R3, err_o is low and check_o is zero. Flipping one bit of the appended check word leaves err_o high.
- R6: While en_i and clr_i are low and sel_i is constant, check_o and err_o do not change, whatever data_i does.
- R7: clr_i is synchronous and takes priority over en_i. On the next edge it loads the start value of the selected setting (0xFFFF for select 7, zero otherwise).
- R8: Driving rst_ni low clears the register to zero at once, without a clock edge, and holds it there until rst_ni returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous master reset, active low, clears the register |
| clr_i | input | 1 | Synchronous clear to the selected start value, wins over en_i |
| en_i | input | 1 | Shift one data bit into the remainder on this edge |
| data_i | input | 1 | Serial data or check bit |
| sel_i | input | 3 | Polynomial setting select |
| check_o | output | 16 | Remainder / check word, masked to the selected degree |
| err_o | output | 1 | Nonzero remainder |

## Verification
The assertions check on every cycle that bits above the selected degree read zero and that the error flag agrees with the remainder. They also check that a clear lands on the start value of the setting, that an idle cycle leaves the outputs unchanged and that the master reset holds the register at zero. Only the bench's scenarios can show that the division itself is right. The bench does this through known check words for all eight settings over a standard test string. Its other scenarios show that appending the check word in the right order returns a zero remainder, that a corrupted check word is caught, and that a reset dropped in the middle of a message clears the register without waiting for a clock.

// File: rtl/crc_sel_pkg.sv
package crc_sel_pkg;
  localparam int unsigned CRC_W = 16;
  localparam int unsigned DEG_W = $clog2(CRC_W + 1);
  localparam int unsigned SEL_W = 3;

  typedef struct packed {
    logic [DEG_W-1:0] degree;
    logic [CRC_W-1:0] poly;
    logic             reflect;
    logic [CRC_W-1:0] start;
  } crc_cfg_t;

  function automatic crc_cfg_t crc_cfg(input logic [SEL_W-1:0] sel);
    crc_cfg_t c;
    c = '{degree: DEG_W'(16), poly: 16'h8005, reflect: 1'b0, start: '0};
    unique case (sel)
      3'd0: c = '{degree: DEG_W'(16), poly: 16'h8005, reflect: 1'b0, start: '0};
      3'd1: c = '{degree: DEG_W'(16), poly: 16'hA001, reflect: 1'b1, start: '0};
      3'd2: c = '{degree: DEG_W'(12), poly: 16'h080F, reflect: 1'b0, start: '0};
      3'd3: c = '{degree: DEG_W'(8),  poly: 16'h0007, reflect: 1'b0, start: '0};
      3'd4: c = '{degree: DEG_W'(16), poly: 16'h1021, reflect: 1'b0, start: '0};
      3'd5: c = '{degree: DEG_W'(16), poly: 16'h8408, reflect: 1'b1, start: '0};
      3'd6: c = '{degree: DEG_W'(8),  poly: 16'h0001, reflect: 1'b0, start: '0};
      3'd7: c = '{degree: DEG_W'(16), poly: 16'h8005, reflect: 1'b0, start: 16'hFFFF};
      default: ;
    endcase
    return c;
  endfunction

  function automatic logic [CRC_W-1:0] deg_mask(input logic [DEG_W-1:0] deg);
    logic [CRC_W:0] one_hot;
    one_hot = (CRC_W+1)'(1) << deg;
    return CRC_W'(one_hot - (CRC_W+1)'(1));
  endfunction
endpackage

// File: rtl/crc_cfg_rom.sv
module crc_cfg_rom
  import crc_sel_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  output crc_cfg_t         cfg_o,
  output logic [CRC_W-1:0] mask_o
);
  crc_cfg_t cfg;

  always_comb begin
    cfg    = crc_cfg(sel_i);
    cfg_o  = cfg;
    mask_o = deg_mask(cfg.degree);
  end
endmodule

// File: rtl/crc_step.sv
module crc_step
  import crc_sel_pkg::*;
(
  input  logic [CRC_W-1:0] rem_i,
  input  logic             data_i,
  input  crc_cfg_t         cfg_i,
  input  logic [CRC_W-1:0] mask_i,
  output logic [CRC_W-1:0] nxt_o
);
  localparam int unsigned IDX_W = $clog2(CRC_W);

  logic [DEG_W-1:0] msb_pos;
  logic [CRC_W-1:0] rem_m;
  logic [CRC_W-1:0] poly_m;
  logic             fb;

  always_comb begin
    rem_m   = rem_i & mask_i;
    poly_m  = cfg_i.poly & mask_i;
    msb_pos = cfg_i.degree - DEG_W'(1);
    if (cfg_i.reflect) begin
      // LSB-out form: data meets bit 0, register moves down
      fb    = data_i ^ rem_m[0];
      nxt_o = (rem_m >> 1) ^ (fb ? poly_m : '0);
    end else begin
      fb    = data_i ^ rem_m[msb_pos[IDX_W-1:0]];
      nxt_o = ((rem_m << 1) & mask_i) ^ (fb ? poly_m : '0);
    end
  end
endmodule

// File: rtl/crc_rem_reg.sv
module crc_rem_reg
  import crc_sel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CRC_W-1:0] start_i,
  input  logic [CRC_W-1:0] nxt_i,
  output logic [CRC_W-1:0] rem_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_o <= '0;
    else if (clr_i)  rem_o <= start_i;
    else if (en_i)   rem_o <= nxt_i;
  end
endmodule

// File: rtl/sel_crc_engine.sv
module sel_crc_engine
  import crc_sel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             data_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CRC_W-1:0] check_o,
  output logic             err_o
);
  crc_cfg_t         cfg;
  logic [CRC_W-1:0] mask;
  logic [CRC_W-1:0] rem_q;
  logic [CRC_W-1:0] rem_d;
  logic [CRC_W-1:0] rem_m;

  crc_cfg_rom u_rom (
    .sel_i  (sel_i),
    .cfg_o  (cfg),
    .mask_o (mask)
  );

  crc_step u_step (
    .rem_i  (rem_q),
    .data_i (data_i),
    .cfg_i  (cfg),
    .mask_i (mask),
    .nxt_o  (rem_d)
  );

  crc_rem_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .en_i    (en_i),
    .start_i (cfg.start),
    .nxt_i   (rem_d),
    .rem_o   (rem_q)
  );

  assign rem_m   = rem_q & mask;
  assign check_o = rem_m;
  assign err_o   = |rem_m;
endmodule

// File: rtl/sel_crc_engine_chk.sv
module sel_crc_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        clr_i,
  input logic        en_i,
  input logic        data_i,
  input logic [2:0]  sel_i,
  input logic [15:0] check_o,
  input logic        err_o
);
  logic [15:0] hi_zero;
  always_comb begin
    case (sel_i)
      3'd2:       hi_zero = 16'hF000;
      3'd3, 3'd6: hi_zero = 16'hFF00;
      default:    hi_zero = 16'h0000;
    endcase
  end

  a_r4_upper_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (check_o & hi_zero) == 16'h0000);

  a_r5_err_matches_rem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o == (check_o != 16'h0000));

  a_r6_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) ##1 $stable(sel_i) |-> $stable(check_o) && $stable(err_o));

  a_r7_clr_start_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i ##1 $stable(sel_i) |-> check_o == ((sel_i == 3'd7) ? 16'hFFFF : 16'h0000));

  a_r8_reset_clears: assert property (@(posedge clk_i)
    !rst_ni |-> (check_o == 16'h0000) && !err_o);

  wire unused_ok = data_i;
endmodule

bind sel_crc_engine sel_crc_engine_chk u_chk (.*);

// File: tb/sel_crc_engine_bench.sv
module sel_crc_engine_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        clr_i = 1'b0;
  logic        en_i = 1'b0;
  logic        data_i = 1'b0;
  logic [2:0]  sel_i = 3'd0;
  logic [15:0] check_o;
  logic        err_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] msg [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};

  sel_crc_engine u_sel_crc_engine (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_refl(input logic [2:0] s);
    return (s == 3'd1) || (s == 3'd5);
  endfunction

  function automatic int degree_of(input logic [2:0] s);
    if (s == 3'd2) return 12;
    if (s == 3'd3 || s == 3'd6) return 8;
    return 16;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk_i);
    en_i = 1'b1; data_i = b;
    @(negedge clk_i);
    en_i = 1'b0;
  endtask

  task automatic clear_start(input logic [2:0] s);
    @(negedge clk_i);
    sel_i = s; clr_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0;
  endtask

  task automatic send_msg(input logic [2:0] s);
    for (int k = 0; k < 9; k++)
      for (int i = 0; i < 8; i++)
        send_bit(is_refl(s) ? msg[k][i] : msg[k][7-i]);
  endtask

  task automatic append_word(input logic [2:0] s, input logic [15:0] w);
    int n = degree_of(s);
    for (int i = 0; i < n; i++)
      send_bit(is_refl(s) ? w[i] : w[n-1-i]);
  endtask

  task automatic t_reset();
    #1 rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R8 reset check_o", 32'(check_o), 32'h0);
    chk("R8 reset err_o", 32'(err_o), 32'h0);
    rst_ni = 1'b1;
  endtask

  task automatic t_vector(input logic [2:0] s, input logic [15:0] exp, input string req);
    logic [15:0] cw;
    clear_start(s);
    send_msg(s);
    chk(req, 32'(check_o), 32'(exp));
    chk("R5 err after message", 32'(err_o), 32'(exp != 16'h0));
    cw = check_o;
    append_word(s, cw);
    chk("R5 zero after own check word", 32'(check_o), 32'h0);
    chk("R5 err low after own check word", 32'(err_o), 32'h0);
  endtask

  task automatic t_corrupt();
    clear_start(3'd4);
    send_msg(3'd4);
    append_word(3'd4, 16'h31C3 ^ 16'h0100);
    chk("R5 corrupted word err_o", 32'(err_o), 32'h1);
  endtask

  task automatic t_hold_and_mask();
    logic [15:0] held;
    clear_start(3'd0);
    send_msg(3'd0);
    held = check_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      data_i = i[0];
    end
    chk("R6 hold with en low", 32'(check_o), 32'(held));
    @(negedge clk_i);
    sel_i = 3'd3;
    #1;
    chk("R4 narrow view of wide remainder", 32'(check_o), 32'h00E8);
    chk("R4 err over low bits", 32'(err_o), 32'h1);
  endtask

  task automatic t_clr_priority();
    @(negedge clk_i);
    sel_i = 3'd7; clr_i = 1'b1; en_i = 1'b1; data_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0; en_i = 1'b0;
    chk("R7 clr beats en, start ones", 32'(check_o), 32'hFFFF);
    @(negedge clk_i);
    sel_i = 3'd4; clr_i = 1'b1; en_i = 1'b1; data_i = 1'b1;
    @(negedge clk_i);
    clr_i = 1'b0; en_i = 1'b0;
    chk("R7 clr beats en, start zero", 32'(check_o), 32'h0);
  endtask

  task automatic t_async();
    clear_start(3'd4);
    for (int i = 0; i < 12; i++) send_bit(1'b1);
    chk("R8 precondition nonzero", 32'(check_o != 16'h0), 32'h1);
    #3 rst_ni = 1'b0;
    #1;
    chk("R8 async clear no clock", 32'(check_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk("R8 held low through reset", 32'(err_o), 32'h0);
  endtask

  initial begin
    t_reset();
    t_vector(3'd0, 16'hFEE8, "R1 R2 sel0 vector");
    t_vector(3'd1, 16'hBB3D, "R1 R3 sel1 vector");
    t_vector(3'd2, 16'h0F5B, "R1 R2 R4 sel2 vector");
    t_vector(3'd3, 16'h00F4, "R1 R2 R4 sel3 vector");
    t_vector(3'd4, 16'h31C3, "R1 R2 sel4 vector");
    t_vector(3'd5, 16'h2189, "R1 R3 sel5 vector");
    t_vector(3'd6, 16'h0031, "R1 R2 sel6 vector");
    t_vector(3'd7, 16'hAEE7, "R1 R2 R7 sel7 vector");
    t_corrupt();
    t_hold_and_mask();
    t_clr_priority();
    t_async();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule